// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Guard

This block sits in front of the page-write logic of a byte-programmable array and watches every bus write on its way there. It recognises two keyed command sequences, each a fixed list of address-and-data pairs. A three-write key arms protection. A six-write key removes it. Both act on a persistent protect flag. A power-up or reset pulse does not clear that flag, so the register that holds it is modelled as a non-volatile cell.

While the flag is set, a page write reaches the array only when the three-write key opens it. The data bytes that follow the key in the same page write are then let through. The block qualifies each write strobe with a write-enable output. Key writes are never passed to the array. When a page write that carried a complete key ends, the block raises a one-cycle request and runs a timed flag-update cycle. Ready stays low from the first key write until that cycle is over. The page logic marks the end of each page write with a timeout pulse.

Top module: `wp_seq_guard`

## Requirements
- R1: After power-up the protect flag is 0 (unprotected). In that state a write that is not part of a key sequence is qualified (`wr_qual`=1 while `wr_stb`=1).
- R2: While the flag is 1, a page write whose first write is not key step one is blocked (`wr_qual`=0), and so is every later write of that page write.
- R3: The arming key is the three writes AAh@5555h, 55h@2AAAh, A0h@5555h. Writes after it in the same page write are qualified. When the page timeout arrives, an update cycle starts. The flag reads 1 once that cycle ends, even when it was 0 before.
- R4: The disarming key is the six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h. Writes after it in the same page write are blocked. At the page timeout an update cycle starts, and the flag reads 0 once that cycle ends.
- R5: While the flag is 1, the arming key followed by data bytes in one page write lets those data bytes through, and the flag stays 1.
- R6: A write accepted as a key step is never qualified.
- R7: A write that does not match the next expected key step aborts the sequence. If the flag is 0, that write and the rest of the page write are qualified. If the flag is 1, they are blocked. The next page write starts matching again at step one.
- R8: A page timeout that arrives with a key only partly entered returns the matcher to idle. No update cycle starts, and `ready_o` returns to 1.
- R9: `ready_o` is 1 when idle. It drops when step one of a key is accepted and stays 0 until the update cycle ends, which is exactly TWC_CYCLES clock cycles after the cycle in which `page_tmo` is sampled.
- R10: Reset clears the matcher and cancels an update cycle in progress, but never changes the protect flag.
- R11: `upd_req` is a one-cycle pulse that appears only with `page_tmo` ending a page write that carried a complete key. Every write made during the update cycle is blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; does not touch the protect flag |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| page_tmo | input | 1 | One-cycle pulse from the page logic ending the current page write |
| wr_qual | output | 1 | Write enable passed to the array for this strobe |
| prot_o | output | 1 | Current protect flag |
| upd_req | output | 1 | Pulse starting a timed flag-update cycle |
| ready_o | output | 1 | 1 when no key sequence or update cycle is in progress |

## Verification
The checker assumes that `page_tmo` and `wr_stb` are never high in the same cycle. It also assumes that `page_tmo` ends a page write only after at least one write. Its properties on key bytes and flag changes hold only under those conditions. The directed stimulus keeps to them. Each write is a single-cycle strobe placed between clock edges, and each page write is closed by its own separate timeout pulse. During an update cycle the bench issues a write only to check that the write is blocked, and it never raises the timeout while that cycle runs.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

   // Key data bytes; positions in the step table define the sequence order.
   localparam logic [7:0] KB_LEAD  = 8'hAA;
   localparam logic [7:0] KB_SECND = 8'h55;
   localparam logic [7:0] KB_ARM   = 8'hA0;
   localparam logic [7:0] KB_DARM1 = 8'h80;
   localparam logic [7:0] KB_DARM2 = 8'h20;

   // hit index: 0..5 disarm steps, 6 = third arming step
   localparam int N_HIT = 7;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_K1,
      ST_K2,
      ST_OPEN,
      ST_D3,
      ST_D4,
      ST_D5,
      ST_SHUT,
      ST_PASS,
      ST_BLOCK
   } seq_st_e;

   function automatic logic [7:0] step_byte(input int idx);
      case (idx)
         0, 3:    return KB_LEAD;
         1, 4:    return KB_SECND;
         2:       return KB_DARM1;
         5:       return KB_DARM2;
         default: return KB_ARM;
      endcase
   endfunction

   function automatic bit step_on_hi(input int idx);
      return (idx == 1) || (idx == 4);
   endfunction

endpackage

// File: rtl/wp_key_match.sv
module wp_key_match
   import wp_seq_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR_LO = 15'h5555,
   parameter logic [ADDR_W-1:0] KEY_ADDR_HI = 15'h2AAA
) (
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [N_HIT-1:0]  hit
);

   for (genvar i = 0; i < N_HIT; i++) begin : g_step
      localparam logic [ADDR_W-1:0] S_ADDR = step_on_hi(i) ? KEY_ADDR_HI : KEY_ADDR_LO;
      localparam logic [DATA_W-1:0] S_DATA = DATA_W'(step_byte(i));
      assign hit[i] = (wr_addr == S_ADDR) && (wr_data == S_DATA);
   end

endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
   import wp_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [N_HIT-1:0] hit,
   input  logic             page_tmo,
   input  logic             upd_busy,
   input  logic             prot,
   output logic             wr_qual,
   output logic             upd_start,
   output logic             upd_val,
   output logic             seq_rest,
   output logic             seq_idle
);

   seq_st_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d      = st_q;
      wr_qual   = 1'b0;
      upd_start = 1'b0;
      upd_val   = 1'b0;
      if (upd_busy) begin
         st_d = ST_IDLE;
      end else if (page_tmo) begin
         st_d = ST_IDLE;
         if (st_q == ST_OPEN) begin
            upd_start = 1'b1;
            upd_val   = 1'b1;
         end else if (st_q == ST_SHUT) begin
            upd_start = 1'b1;
         end
      end else if (wr_stb) begin
         case (st_q)
            ST_IDLE: begin
               if (hit[0]) st_d = ST_K1;
               else begin
                  wr_qual = !prot;
                  st_d    = prot ? ST_BLOCK : ST_PASS;
               end
            end
            ST_K1: begin
               if (hit[1]) st_d = ST_K2;
               else begin
                  wr_qual = !prot;
                  st_d    = prot ? ST_BLOCK : ST_PASS;
               end
            end
            ST_K2: begin
               if (hit[6])      st_d = ST_OPEN;
               else if (hit[2]) st_d = ST_D3;
               else begin
                  wr_qual = !prot;
                  st_d    = prot ? ST_BLOCK : ST_PASS;
               end
            end
            ST_D3, ST_D4, ST_D5: begin
               if (st_q == ST_D3 && hit[3])      st_d = ST_D4;
               else if (st_q == ST_D4 && hit[4]) st_d = ST_D5;
               else if (st_q == ST_D5 && hit[5]) st_d = ST_SHUT;
               else begin
                  wr_qual = !prot;
                  st_d    = prot ? ST_BLOCK : ST_PASS;
               end
            end
            ST_OPEN, ST_PASS: wr_qual = 1'b1;
            default:          wr_qual = 1'b0;
         endcase
      end
   end

   assign seq_idle = (st_q == ST_IDLE);
   assign seq_rest = !upd_busy &&
                     (st_q == ST_IDLE || st_q == ST_PASS || st_q == ST_BLOCK);

endmodule

// File: rtl/wp_upd_timer.sv
module wp_upd_timer #(
   parameter int TWC_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic val,
   output logic busy,
   output logic done,
   output logic pend
);

   localparam int CW = $clog2(TWC_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pend  <= 1'b0;
      end else if (start) begin
         cnt_q <= CW'(TWC_CYCLES);
         pend  <= val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/wp_prot_cell.sv
module wp_prot_cell (
   input  logic clk,
   input  logic load,
   input  logic val,
   output logic prot
);

   // Non-volatile cell model: power-up value only, no reset.
   logic prot_q = 1'b0;

   always_ff @(posedge clk) begin
      if (load) prot_q <= val;
   end

   assign prot = prot_q;

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
   import wp_seq_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter int TWC_CYCLES = 64,
   parameter logic [ADDR_W-1:0] KEY_ADDR_LO = 15'h5555,
   parameter logic [ADDR_W-1:0] KEY_ADDR_HI = 15'h2AAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              page_tmo,
   output logic              wr_qual,
   output logic              prot_o,
   output logic              upd_req,
   output logic              ready_o
);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("wp_seq_guard: DATA_W must hold a key byte");
   end
   if (TWC_CYCLES < 1) begin : g_bad_twc
      $error("wp_seq_guard: TWC_CYCLES must be at least 1");
   end
   if (KEY_ADDR_LO == KEY_ADDR_HI) begin : g_bad_keys
      $error("wp_seq_guard: key addresses must differ");
   end

   logic [N_HIT-1:0] hit;
   logic upd_busy, upd_done, upd_pend, upd_val;
   logic seq_idle;

   wp_key_match #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .KEY_ADDR_LO(KEY_ADDR_LO),
      .KEY_ADDR_HI(KEY_ADDR_HI)
   ) match_i (
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .hit    (hit)
   );

   wp_seq_fsm fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .hit      (hit),
      .page_tmo (page_tmo),
      .upd_busy (upd_busy),
      .prot     (prot_o),
      .wr_qual  (wr_qual),
      .upd_start(upd_req),
      .upd_val  (upd_val),
      .seq_rest (ready_o),
      .seq_idle (seq_idle)
   );

   wp_upd_timer #(.TWC_CYCLES(TWC_CYCLES)) timer_i (
      .clk  (clk),
      .rst_n(rst_n),
      .start(upd_req),
      .val  (upd_val),
      .busy (upd_busy),
      .done (upd_done),
      .pend (upd_pend)
   );

   wp_prot_cell cell_i (
      .clk (clk),
      .load(upd_done),
      .val (upd_pend),
      .prot(prot_o)
   );

endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR_LO = 15'h5555
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              page_tmo,
   input logic              wr_qual,
   input logic              prot_o,
   input logic              upd_req,
   input logic              ready_o,
   input logic              upd_busy,
   input logic              seq_idle
);

   // R11
   qual_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_qual |-> wr_stb);

   // R6
   lead_key_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && seq_idle && !upd_busy && wr_addr == KEY_ADDR_LO &&
       wr_data == DATA_W'(8'hAA)) |-> !wr_qual);

   // R2
   prot_pass_only_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_qual && prot_o) |-> !ready_o);

   // R10
   flag_moves_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_o) |-> $past(!ready_o));

   // R11
   req_with_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req |-> page_tmo);

   // R9
   req_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req |=> !ready_o);

   // R11
   busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_busy |-> !wr_qual);

endmodule

bind wp_seq_guard wp_seq_guard_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .KEY_ADDR_LO(KEY_ADDR_LO)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_stb  (wr_stb),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .page_tmo(page_tmo),
   .wr_qual (wr_qual),
   .prot_o  (prot_o),
   .upd_req (upd_req),
   .ready_o (ready_o),
   .upd_busy(upd_busy),
   .seq_idle(seq_idle)
);

// File: tb/wp_seq_guard_tb_top.sv
module wp_seq_guard_tb_top;

   localparam int AW  = 15;
   localparam int DW  = 8;
   localparam int TWC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          page_tmo = 1'b0;
   logic          wr_qual, prot_o, upd_req, ready_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   wp_seq_guard #(.ADDR_W(AW), .DATA_W(DW), .TWC_CYCLES(TWC)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .page_tmo(page_tmo),
      .wr_qual (wr_qual),
      .prot_o  (prot_o),
      .upd_req (upd_req),
      .ready_o (ready_o)
   );

   task automatic chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic exp, input string tag);
      @(negedge clk);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      #1 chk(wr_qual, exp, tag);
      @(posedge clk);
      #1 wr_stb = 1'b0;
   endtask

   task automatic page_end(input logic exp_req, input string tag);
      @(negedge clk);
      page_tmo = 1'b1;
      #1 chk(upd_req, exp_req, tag);
      @(posedge clk);
      #1 page_tmo = 1'b0;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      @(negedge clk);
      while (!ready_o && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic arm_key();
      wr(15'h5555, 8'hAA, 1'b0, "R6 arm step1");
      wr(15'h2AAA, 8'h55, 1'b0, "R6 arm step2");
      wr(15'h5555, 8'hA0, 1'b0, "R6 arm step3");
   endtask

   task automatic disarm_key();
      wr(15'h5555, 8'hAA, 1'b0, "R6 disarm step1");
      wr(15'h2AAA, 8'h55, 1'b0, "R6 disarm step2");
      wr(15'h5555, 8'h80, 1'b0, "R6 disarm step3");
      wr(15'h5555, 8'hAA, 1'b0, "R6 disarm step4");
      wr(15'h2AAA, 8'h55, 1'b0, "R6 disarm step5");
      wr(15'h5555, 8'h20, 1'b0, "R6 disarm step6");
   endtask

   task automatic t_reset_state();
      #1;
      chk(prot_o, 1'b0, "R1 power-up flag");
      chk(ready_o, 1'b1, "R9 ready after reset");
      chk(upd_req, 1'b0, "R11 no request at reset");
   endtask

   task automatic t_plain_unprot();
      wr(15'h0100, 8'h12, 1'b1, "R1 plain write 1");
      wr(15'h0101, 8'h34, 1'b1, "R1 plain write 2");
      page_end(1'b0, "R11 no request after plain page");
   endtask

   task automatic t_abort_unprot();
      wr(15'h5555, 8'hAA, 1'b0, "R6 lone lead byte");
      #1 chk(ready_o, 1'b0, "R9 ready low after step1");
      wr(15'h0200, 8'h33, 1'b1, "R7 mismatch passes unprotected");
      #1 chk(ready_o, 1'b1, "R9 ready back after abort");
      wr(15'h0201, 8'h34, 1'b1, "R7 rest of page passes");
      page_end(1'b0, "R7 no request after abort");
   endtask

   task automatic t_first_arm();
      int n;
      arm_key();
      wr(15'h0300, 8'h77, 1'b1, "R3 data after first arm key");
      page_end(1'b1, "R11 request after arm page");
      wr(15'h0301, 8'h78, 1'b0, "R11 write during update blocked");
      wait_ready(n);
      chk(prot_o, 1'b1, "R3 flag set after cycle");
   endtask

   task automatic t_prot_plain();
      wr(15'h0400, 8'h11, 1'b0, "R2 plain write blocked");
      wr(15'h5555, 8'hAA, 1'b0, "R2 later key byte blocked in page");
      wr(15'h0401, 8'h22, 1'b0, "R2 rest of page blocked");
      page_end(1'b0, "R2 no request");
   endtask

   task automatic t_prot_unlock();
      int n;
      arm_key();
      wr(15'h0500, 8'h5A, 1'b1, "R5 unlocked data 1");
      wr(15'h0501, 8'h5B, 1'b1, "R5 unlocked data 2");
      page_end(1'b1, "R11 request after unlocked page");
      wait_ready(n);
      n_chk++;
      if (n != TWC) begin
         n_bad++;
         $display("FAIL R9 update length: got %0d expected %0d", n, TWC);
      end
      chk(prot_o, 1'b1, "R5 flag stays set");
   endtask

   task automatic t_prot_mismatch();
      wr(15'h5555, 8'hAA, 1'b0, "R6 step1 protected");
      wr(15'h2AAA, 8'h55, 1'b0, "R6 step2 protected");
      wr(15'h5555, 8'h99, 1'b0, "R7 bad step3 blocked");
      wr(15'h0600, 8'h44, 1'b0, "R7 rest after abort blocked");
      page_end(1'b0, "R7 no request after abort");
      arm_key();
      wr(15'h0601, 8'h45, 1'b1, "R7 restart at step one");
      page_end(1'b1, "R7 request after restart");
      begin
         int n;
         wait_ready(n);
      end
   endtask

   task automatic t_tmo_mid();
      wr(15'h5555, 8'hAA, 1'b0, "R6 step1 before timeout");
      wr(15'h2AAA, 8'h55, 1'b0, "R6 step2 before timeout");
      page_end(1'b0, "R8 no request on partial key");
      #1 chk(ready_o, 1'b1, "R8 ready after partial key");
      wr(15'h5555, 8'hA0, 1'b0, "R8 step3 alone is plain and blocked");
      page_end(1'b0, "R8 no request on stray step3");
      chk(prot_o, 1'b1, "R8 flag unchanged");
   endtask

   task automatic t_reset_keeps();
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 chk(prot_o, 1'b1, "R10 flag held in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(prot_o, 1'b1, "R10 flag after reset");
      chk(ready_o, 1'b1, "R10 ready after reset");
   endtask

   task automatic t_reset_mid_update();
      disarm_key();
      wr(15'h0800, 8'h66, 1'b0, "R4 write after disarm key blocked");
      page_end(1'b1, "R11 request after disarm page");
      repeat (5) @(negedge clk);
      chk(ready_o, 1'b0, "R9 ready low during update");
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready_o, 1'b1, "R10 update cancelled");
      repeat (TWC) @(negedge clk);
      chk(prot_o, 1'b1, "R10 cancelled update leaves flag");
   endtask

   task automatic t_disarm();
      int n;
      disarm_key();
      page_end(1'b1, "R11 request after disarm");
      wait_ready(n);
      chk(prot_o, 1'b0, "R4 flag cleared");
      wr(15'h0900, 8'h10, 1'b1, "R4 plain write after clear");
      page_end(1'b0, "R4 no request");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_plain_unprot();
      t_abort_unprot();
      t_first_arm();
      t_prot_plain();
      t_prot_unlock();
      t_prot_mismatch();
      t_tmo_mid();
      t_reset_keeps();
      t_reset_mid_update();
      t_disarm();
      repeat (4) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule